// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. It samples the line on a free-running tick at sixteen times the bit rate. A start bit is accepted only if the line is still low halfway through that bit. Each later bit is taken once, at its centre. The character width is 5 to 8 data bits, received LSB first. An optional parity bit can follow the data, and the frame ends with one stop bit.

Characters that pass the frame checks go into a 16-entry first-in first-out store. The store has a first-word-fall-through read port. Three single-cycle error pulses report parity, framing and overrun events. A register block elsewhere latches these pulses into sticky flags. Each error class has its own storage rule:
- A character with a parity error is still stored.
- A character with a bad stop bit is discarded.
- A character that arrives while the store is full is discarded.

The tick, the line and the configuration inputs come from outside. The configuration may only change while the line is idle.

Top module: `srx_receiver`

## Requirements
- R1: After reset the store is empty (`rx_avail_o`=0, `rx_full_o`=0) and no error pulse is raised.
- R2: `cfg_width_i` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2, 3. Data bits arrive LSB first. The stored character appears on `rx_data_o` right-aligned, with unused upper bits zero.
- R3: With `cfg_par_on_i`=1, `cfg_par_odd_i`=0 selects even parity: data plus parity bit hold an even number of ones. `cfg_par_odd_i`=1 selects odd parity. A correct parity bit stores the character with no pulse.
- R4: A wrong parity bit still stores the character and raises `err_parity_o` for exactly one clock.
- R5: With `cfg_par_on_i`=0 no parity bit is expected, the bit after the data is the stop bit, and `err_parity_o` never asserts.
- R6: A stop bit sampled as 0 raises `err_frame_o` alone for one clock, and the character is not stored.
- R7: A character that completes while the store holds 16 entries raises `err_overrun_o` and is dropped. The stored entries are kept unchanged.
- R8: After a falling edge, the line is sampled again 8 ticks later. If it is high then, reception is abandoned with nothing stored and no pulse raised.
- R9: The store returns characters in arrival order. `rx_full_o` is 1 exactly when it holds 16. A `rx_pop_i` pulse while `rx_avail_o`=1 removes the head.
- R10: A character with a wrong parity bit that arrives while the store is full raises `err_parity_o` and `err_overrun_o` in the same clock, and is not stored.
- R11: A new reception starts only on a high-to-low transition. A line held low after a framing error starts no new character until it has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-clock strobe at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| cfg_width_i | input | 2 | Data width code, 0..3 for 5..8 bits |
| cfg_par_on_i | input | 1 | 1 = a parity bit follows the data |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_pop_i | input | 1 | Removes the head entry of the store |
| rx_data_o | output | 8 | Head entry of the store, right-aligned |
| rx_avail_o | output | 1 | Store holds at least one character |
| rx_full_o | output | 1 | Store holds 16 characters |
| err_parity_o | output | 1 | One-clock parity error pulse |
| err_frame_o | output | 1 | One-clock framing error pulse |
| err_overrun_o | output | 1 | One-clock overrun pulse |

## Verification
Two verdicts can fall on the same stop-bit sample: the parity judgement and the overrun judgement. To provoke this, the bench fills the store with sixteen characters and never pops. It then sends one character with a good parity bit and one with a corrupted parity bit. The scoreboard expects an overrun pulse alone for the first character, and parity and overrun pulses together in the same clock for the second. It then drains the store to confirm that neither character entered it and that the first sixteen are still in order.

// File: rtl/srx_pkg.sv
// Shared definitions for the serial receiver.
// Assumes a 16x oversampling tick and characters of at most 8 bits.
package srx_pkg;
    localparam int OSR      = 16;
    localparam int MAX_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
// Two-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high, so the flops reset to 1.
module srx_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    // Bring the line into the clock domain in two stages.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/srx_fifo.sv
// Receive store: first-word-fall-through FIFO.
// Assumes DEPTH is a power of two. Writes while full are ignored;
// the caller is expected to check full_o first.
module srx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             avail_o,
    output logic             full_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [AW:0]      count_q;
    logic             do_push, do_pop;

    assign avail_o = (count_q != '0);
    assign full_o  = (count_q == (AW+1)'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && avail_o;
    assign head_o  = mem_q[rptr_q];

    // Storage array write.
    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[wptr_q] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            count_q <= count_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/srx_framer.sv
// Bit-level receive state machine. It finds a falling edge on the
// synchronized line, confirms the start bit at half a bit, samples
// data, parity and stop at bit centres, and then decides whether to
// store the character and which error pulses to raise.
// Assumes the configuration inputs are stable during a frame.
module srx_framer
    import srx_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                line_i,
    input  logic [1:0]          cfg_width_i,
    input  logic                cfg_par_on_i,
    input  logic                cfg_par_odd_i,
    input  logic                store_full_i,
    output logic                push_o,
    output logic [MAX_BITS-1:0] push_data_o,
    output logic                par_err_o,
    output logic                frm_err_o,
    output logic                ovr_err_o
);
    localparam int          TW       = $clog2(OSR);
    localparam int          BW       = $clog2(MAX_BITS);
    localparam logic [TW-1:0] HALF_LAST = TW'(OSR/2 - 1);
    localparam logic [TW-1:0] FULL_LAST = TW'(OSR - 1);

    rx_state_e            state_q;
    logic [TW-1:0]        tcnt_q;
    logic [BW-1:0]        bidx_q;
    logic [MAX_BITS-1:0]  shreg_q;
    logic                 pacc_q;
    logic                 perr_q;
    logic                 prev_q;
    logic [BW-1:0]        last_idx;

    assign last_idx = {1'b0, cfg_width_i} + BW'(4);

    // Receive sequencing, sampling and verdict pulses.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            tcnt_q      <= '0;
            bidx_q      <= '0;
            shreg_q     <= '0;
            pacc_q      <= 1'b0;
            perr_q      <= 1'b0;
            prev_q      <= 1'b1;
            push_o      <= 1'b0;
            push_data_o <= '0;
            par_err_o   <= 1'b0;
            frm_err_o   <= 1'b0;
            ovr_err_o   <= 1'b0;
        end else begin
            push_o    <= 1'b0;
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
            ovr_err_o <= 1'b0;
            if (tick_i) begin
                prev_q <= line_i;
                unique case (state_q)
                    ST_IDLE: begin
                        if (prev_q && !line_i) begin
                            state_q <= ST_START;
                            tcnt_q  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt_q == HALF_LAST) begin
                            tcnt_q  <= '0;
                            bidx_q  <= '0;
                            shreg_q <= '0;
                            pacc_q  <= 1'b0;
                            perr_q  <= 1'b0;
                            state_q <= line_i ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tcnt_q == FULL_LAST) begin
                            tcnt_q          <= '0;
                            shreg_q[bidx_q] <= line_i;
                            pacc_q          <= pacc_q ^ line_i;
                            if (bidx_q == last_idx)
                                state_q <= cfg_par_on_i ? ST_PAR : ST_STOP;
                            else
                                bidx_q <= bidx_q + 1'b1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (tcnt_q == FULL_LAST) begin
                            tcnt_q  <= '0;
                            perr_q  <= line_i ^ pacc_q ^ cfg_par_odd_i;
                            state_q <= ST_STOP;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt_q == FULL_LAST) begin
                            tcnt_q  <= '0;
                            state_q <= ST_IDLE;
                            if (!line_i) begin
                                frm_err_o <= 1'b1;
                            end else begin
                                par_err_o <= perr_q;
                                if (store_full_i) begin
                                    ovr_err_o <= 1'b1;
                                end else begin
                                    push_o      <= 1'b1;
                                    push_data_o <= shreg_q;
                                end
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_receiver.sv
// Top of the serial receiver: synchronizer, framer and receive store.
// Assumes tick_i is a one-clock strobe at 16x the bit rate and that
// the configuration changes only while the line is idle.
module srx_receiver
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                rxd_i,
    input  logic [1:0]          cfg_width_i,
    input  logic                cfg_par_on_i,
    input  logic                cfg_par_odd_i,
    input  logic                rx_pop_i,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                rx_avail_o,
    output logic                rx_full_o,
    output logic                err_parity_o,
    output logic                err_frame_o,
    output logic                err_overrun_o
);
    logic                line_s;
    logic                push_s;
    logic [MAX_BITS-1:0] push_data_s;

    srx_sync i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rxd_i),
        .q_o    (line_s)
    );

    srx_framer i_framer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick_i),
        .line_i        (line_s),
        .cfg_width_i   (cfg_width_i),
        .cfg_par_on_i  (cfg_par_on_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .store_full_i  (rx_full_o),
        .push_o        (push_s),
        .push_data_o   (push_data_s),
        .par_err_o     (err_parity_o),
        .frm_err_o     (err_frame_o),
        .ovr_err_o     (err_overrun_o)
    );

    srx_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (MAX_BITS)
    ) i_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push_s),
        .push_data_i (push_data_s),
        .pop_i       (rx_pop_i),
        .head_o      (rx_data_o),
        .avail_o     (rx_avail_o),
        .full_o      (rx_full_o)
    );
endmodule

// File: rtl/srx_receiver_chk.sv
// Property checker for the serial receiver, bound to the top module.
// Assumes it observes only the top-level ports.
module srx_receiver_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cfg_par_on_i,
    input logic rx_avail_o,
    input logic rx_full_o,
    input logic err_parity_o,
    input logic err_frame_o,
    input logic err_overrun_o
);
    // A framing verdict stands alone.
    assert_frame_alone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_frame_o |-> (!err_parity_o && !err_overrun_o));

    // A parity error pulse needs parity to be enabled.
    assert_no_parity_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_parity_o |-> cfg_par_on_i);

    // A parity pulse lasts one clock.
    assert_parity_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_parity_o |=> !err_parity_o);

    // An overrun occurs only when the store is full.
    assert_overrun_needs_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_overrun_o |-> rx_full_o);

    // A full store also reports data available.
    assert_full_implies_avail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_full_o |-> rx_avail_o);

    // Coming out of reset the store reports empty.
    assert_reset_empty_R1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!rx_avail_o && !rx_full_o));
endmodule

bind srx_receiver srx_receiver_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_par_on_i  (cfg_par_on_i),
    .rx_avail_o    (rx_avail_o),
    .rx_full_o     (rx_full_o),
    .err_parity_o  (err_parity_o),
    .err_frame_o   (err_frame_o),
    .err_overrun_o (err_overrun_o)
);

// File: tb/test_srx_receiver.sv
// Scoreboard bench: driver tasks queue expected events and characters,
// a monitor compares error pulses and a drain task compares the store.
module test_srx_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_w = 2'd3;
    logic       cfg_pon = 1'b0;
    logic       cfg_podd = 1'b0;
    logic       pop = 1'b0;
    logic [7:0] q;
    logic       avail, full, e_par, e_frm, e_ovr;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] ev_q[$];   // {parity, frame, overrun}
    logic [7:0] data_q[$];

    localparam int BITCLK = 64;  // 16 ticks of 4 clocks each

    always #10 clk = ~clk;

    srx_receiver i_srx_receiver (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tick_i        (tick),
        .rxd_i         (rxd),
        .cfg_width_i   (cfg_w),
        .cfg_par_on_i  (cfg_pon),
        .cfg_par_odd_i (cfg_podd),
        .rx_pop_i      (pop),
        .rx_data_o     (q),
        .rx_avail_o    (avail),
        .rx_full_o     (full),
        .err_parity_o  (e_par),
        .err_frame_o   (e_frm),
        .err_overrun_o (e_ovr)
    );

    // Tick strobe: one clock in four.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every error pulse is compared with the expected event queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (e_par || e_frm || e_ovr)) begin
                if (ev_q.size() == 0) check("R5/R8/R11 unexpected pulse", {e_par, e_frm, e_ovr}, 3'b000);
                else check("R4/R6/R7/R10 pulse", {e_par, e_frm, e_ovr}, ev_q.pop_front());
            end
        end
    end

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    // Driver: sends one frame and queues what it should produce.
    task automatic send(input logic [7:0] d, input int nb, input bit pe, input bit odd,
                        input bit badp, input bit stopv, input int hold);
        logic [7:0] m;
        logic       pbit;
        cfg_w    = 2'(nb - 5);
        cfg_pon  = pe;
        cfg_podd = odd;
        m    = d & 8'((1 << nb) - 1);
        pbit = (^m) ^ odd ^ badp;
        if (!stopv) ev_q.push_back(3'b010);
        else if (data_q.size() == 16) ev_q.push_back({pe && badp, 1'b0, 1'b1});
        else begin
            data_q.push_back(m);
            if (pe && badp) ev_q.push_back(3'b100);
        end
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(m[i]);
        if (pe) drive_bit(pbit);
        drive_bit(stopv);
        if (hold > 0) begin
            rxd = 1'b0;
            repeat (hold) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    // Empties the store, comparing each head in arrival order (R9, R2).
    task automatic drain(input string req);
        while (data_q.size() > 0) begin
            @(negedge clk);
            check(req, {31'd0, avail}, 32'd1);
            check(req, {24'd0, q}, {24'd0, data_q.pop_front()});
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
        @(negedge clk);
        check(req, {31'd0, avail}, 32'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 avail", {31'd0, avail}, 32'd0);
        check("R1 full", {31'd0, full}, 32'd0);
        repeat (20) @(negedge clk);

        // R2 widths, LSB first; R5 parity off
        send(8'hA5, 8, 0, 0, 0, 1, 0);
        send(8'h3C, 8, 0, 0, 0, 1, 0);
        send(8'hF3, 5, 0, 0, 0, 1, 0);
        send(8'hEA, 6, 0, 0, 0, 1, 0);
        send(8'hD5, 7, 0, 0, 0, 1, 0);
        drain("R2 width/order");

        // R3 good parity even and odd
        send(8'h96, 8, 1, 0, 0, 1, 0);
        send(8'h07, 8, 1, 1, 0, 1, 0);
        send(8'h15, 5, 1, 1, 0, 1, 0);
        drain("R3 good parity");

        // R4 bad parity still stored
        send(8'h5A, 8, 1, 0, 1, 1, 0);
        send(8'h01, 7, 1, 1, 1, 1, 0);
        drain("R4 parity error stored");

        // R6 frame error, R11 line held low afterwards
        send(8'h77, 8, 0, 0, 0, 0, 4 * BITCLK);
        send(8'h42, 8, 1, 0, 0, 0, 0);
        repeat (4 * BITCLK) @(negedge clk);
        check("R6/R11 nothing stored", {31'd0, avail}, 32'd0);

        // R8 short glitch rejected
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        check("R8 glitch", {31'd0, avail}, 32'd0);
        send(8'h81, 8, 0, 0, 0, 1, 0);
        drain("R8 recovery");

        // R9 fill, R7 overrun, R10 parity and overrun together
        for (int k = 0; k < 16; k++) send(8'(k * 17 + 3), 8, 1, 0, 0, 1, 0);
        check("R9 full", {31'd0, full}, 32'd1);
        send(8'hEE, 8, 1, 0, 0, 1, 0);
        send(8'hDD, 8, 1, 0, 1, 1, 0);
        check("R7 still full", {31'd0, full}, 32'd1);
        drain("R7/R10 contents kept");

        repeat (50) @(negedge clk);
        check("R4-R10 events consumed", ev_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule